// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an asynchronous 512K x 16 static RAM whose two byte halves can each be enabled on their own. The host hands over one word at a time through a valid/ready handshake. Each request carries a 19-bit address, 16-bit write data, a 2-bit byte mask and a read/write flag. The controller then plays out a correctly timed cycle on the memory pins. Reads come back on a data port together with a one-cycle valid strobe.

All memory-side timing comes from cycle-count parameters. Their defaults are derived from the clock period, and each is at least one cycle. The nanosecond limits behind them are as follows. A read needs 70 ns of access. A write strobe must be at least 55 ns long. A full write must span at least 70 ns. Write data must be set up 35 ns before the strobe ends. The memory may take up to 25 ns to release the bus after output enable or chip select goes high, so the controller waits that long before it drives the shared data bus itself.

Writes are strobed by the write-enable pin. Output enable stays high for the whole write. Chip select and the byte controls are asserted before write enable falls, so the memory outputs stay off while the controller drives the bus.

Top module: `sramc_top`

## Requirements
- R1: A read keeps chip select and output enable low and write enable high for exactly RD_CYC cycles. The word on the bus at the end of that window is returned on rsp_rdata, and rsp_valid is high in the cycle that begins RD_CYC clock edges after the accepting edge.
- R2: Mask bit 0 selects data bits 7:0 through byte control 0, and mask bit 1 selects bits 15:8 through byte control 1. Any byte of rsp_rdata whose mask bit is 0 reads as zero.
- R3: A write changes only the bytes whose mask bit is 1. A write with mask 00 leaves the addressed word unchanged.
- R4: During a write, write enable is low for exactly WP_CYC cycles, and output enable stays high throughout. Chip select is already low in the cycle before write enable falls.
- R5: The memory address does not change while chip select is low.
- R6: The controller drives the data bus only during a write. It holds the write data from the fall of write enable through one cycle after write enable rises. It starts driving no sooner than TURN_CYC cycles after output enable was last low, and never while output enable is low.
- R7: req_ready drops at the accepting edge. It returns high RD_CYC+TURN_CYC cycles later for a read, and TURN_CYC+WP_CYC+1 cycles later for a write.
- R8: rsp_valid is a single-cycle pulse that occurs once per read and never for a write.
- R9: While reset is applied and right after it is released, req_ready is 1, rsp_valid is 0, and chip select, write enable, output enable and both byte controls are high.
- R10: Every cycle-count parameter is at least 1, and each count multiplied by CLK_NS meets its nanosecond minimum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; a request is accepted when both are high |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte select; bit 0 is the low byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data; unselected bytes are zero |
| sram_addr | output | 19 | Memory address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_bc_n | output | 2 | Byte controls, active low; bit 0 gates bits 7:0 |
| sram_dq | inout | 16 | Shared data bus |

## Verification
If a phase counter is loaded with the wrong length, the fault shows up within the same request. The strobe width, the response latency and the length of the busy window each come out a cycle off, and are checked against counts computed from the timing arithmetic. If the latched mask or address goes wrong, bytes land in the wrong place or neighbouring bytes get overwritten. That becomes visible at the next read of that word. The sweep follows every masked write with both a full-word read and a masked read. A wrong bus-drive state shows up as data contention during a read, or as a missing write, within one request.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    localparam int T_READ_NS  = 70;
    localparam int T_WPULSE_NS = 55;
    localparam int T_WCYCLE_NS = 70;
    localparam int T_DSETUP_NS = 35;
    localparam int T_FLOAT_NS  = 25;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_FLT,
        ST_WR_SET,
        ST_WR_PUL,
        ST_WR_REC
    } state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic sel;
        logic drive;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, sel: 1'b0, drive: 1'b0};

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int phase_len(input state_e s, input int rd, input int turn,
                                     input int wp, input int rec);
        case (s)
            ST_RD_ACC: return rd;
            ST_RD_FLT: return turn;
            ST_WR_SET: return turn;
            ST_WR_PUL: return wp;
            ST_WR_REC: return rec;
            default:   return 1;
        endcase
    endfunction

    function automatic pins_t phase_pins(input state_e s);
        pins_t p;
        p = PINS_IDLE;
        case (s)
            ST_RD_ACC: begin p.cs_n = 1'b0; p.oe_n = 1'b0; p.sel = 1'b1; end
            ST_WR_SET: begin p.cs_n = 1'b0; p.sel = 1'b1; end
            ST_WR_PUL: begin p.cs_n = 1'b0; p.we_n = 1'b0; p.sel = 1'b1; p.drive = 1'b1; end
            ST_WR_REC: begin p.cs_n = 1'b0; p.sel = 1'b1; p.drive = 1'b1; end
            default:   p = PINS_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CW'(1);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q > CW'(1)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/sramc_lanes.sv
module sramc_lanes #(
    parameter int LANES = 2
) (
    input  logic               sel,
    input  logic [LANES-1:0]   mask,
    output logic [LANES-1:0]   bc_n,
    output logic [LANES*8-1:0] keep
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign bc_n[i]        = ~(sel & mask[i]);
        assign keep[i*8 +: 8] = {8{mask[i]}};
    end
endmodule

// File: rtl/sramc_dq.sv
module sramc_dq #(
    parameter int DATA_W = 16
) (
    input  logic              drive,
    input  logic [DATA_W-1:0] wdata,
    inout  wire  [DATA_W-1:0] dq,
    output logic [DATA_W-1:0] rdata
);
    assign dq    = drive ? wdata : {DATA_W{1'bz}};
    assign rdata = dq;
endmodule

// File: rtl/sramc_top.sv
module sramc_top
    import sramc_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 16,
    parameter int CLK_NS   = 8,
    parameter int RD_CYC   = ns_to_cyc(T_READ_NS, CLK_NS),
    parameter int TURN_CYC = ns_to_cyc(T_FLOAT_NS, CLK_NS),
    parameter int WP_CYC   = ns_to_cyc(T_WPULSE_NS, CLK_NS),
    parameter int REC_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W/8-1:0] sram_bc_n,
    inout  wire  [DATA_W-1:0] sram_dq
);
    localparam int LANES = DATA_W / 8;
    localparam int MAXC  = max4(RD_CYC, TURN_CYC, WP_CYC, REC_CYC);
    localparam int CW    = $clog2(MAXC + 1);

    state_e            state_q, state_d;
    pins_t             pins_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] dq_in;
    logic [DATA_W-1:0] keep;
    logic              phase_done;
    logic              advance;
    logic              accept;
    logic [CW-1:0]     next_len;
    logic              dq_drive;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (req_valid) state_d = req_write ? ST_WR_SET : ST_RD_ACC;
            ST_RD_ACC: if (phase_done) state_d = ST_RD_FLT;
            ST_RD_FLT: if (phase_done) state_d = ST_IDLE;
            ST_WR_SET: if (phase_done) state_d = ST_WR_PUL;
            ST_WR_PUL: if (phase_done) state_d = ST_WR_REC;
            ST_WR_REC: if (phase_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign advance  = (state_d != state_q);
    assign next_len = CW'(phase_len(state_d, RD_CYC, TURN_CYC, WP_CYC, REC_CYC));

    sramc_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (advance),
        .load_val (next_len),
        .done     (phase_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pins_q    <= PINS_IDLE;
            addr_q    <= '0;
            wdata_q   <= '0;
            mask_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            state_q   <= state_d;
            pins_q    <= phase_pins(state_d);
            rsp_valid <= (state_q == ST_RD_ACC) && phase_done;
            if ((state_q == ST_RD_ACC) && phase_done) begin
                rsp_rdata <= dq_in & keep;
            end
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
            end
        end
    end

    sramc_lanes #(.LANES(LANES)) u_lanes (
        .sel  (pins_q.sel),
        .mask (mask_q),
        .bc_n (sram_bc_n),
        .keep (keep)
    );

    assign dq_drive = pins_q.drive;

    sramc_dq #(.DATA_W(DATA_W)) u_dq (
        .drive (dq_drive),
        .wdata (wdata_q),
        .dq    (sram_dq),
        .rdata (dq_in)
    );

    assign sram_addr = addr_q;
    assign sram_cs_n = pins_q.cs_n;
    assign sram_we_n = pins_q.we_n;
    assign sram_oe_n = pins_q.oe_n;
endmodule

// File: rtl/sramc_checker.sv
module sramc_checker #(
    parameter int ADDR_W   = 19,
    parameter int LANES    = 2,
    parameter int CLK_NS   = 8,
    parameter int RD_CYC   = 9,
    parameter int TURN_CYC = 4,
    parameter int WP_CYC   = 7,
    parameter int REC_CYC  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              drive,
    input logic              ready,
    input logic              req_valid,
    input logic              rsp_valid
);
    logic [15:0] we_lo_cnt;
    logic [15:0] oe_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo_cnt <= '0;
            oe_gap    <= 16'(TURN_CYC);
        end else begin
            we_lo_cnt <= !we_n ? we_lo_cnt + 16'd1 : 16'd0;
            if (!oe_n) oe_gap <= 16'd0;
            else if (oe_gap != 16'hFFFF) oe_gap <= oe_gap + 16'd1;
        end
    end

    initial begin
        assert_param_min_R10: assert (RD_CYC >= 1 && TURN_CYC >= 1 && WP_CYC >= 1 && REC_CYC >= 1);
        assert_param_read_R10: assert (RD_CYC * CLK_NS >= 70);
        assert_param_pulse_R10: assert (WP_CYC * CLK_NS >= 55 && WP_CYC * CLK_NS >= 35);
        assert_param_float_R10: assert (TURN_CYC * CLK_NS >= 25);
        assert_param_wcycle_R10: assert ((TURN_CYC + WP_CYC + REC_CYC) * CLK_NS >= 70);
    end

    assert_we_in_select_R4: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!cs_n && oe_n));

    assert_cs_before_we_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |-> $past(!cs_n));

    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (we_lo_cnt == 16'(WP_CYC)));

    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> $stable(addr));

    assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !drive);

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(drive) |-> (oe_gap >= 16'(TURN_CYC)));

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready) |=> !ready);

    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind sramc_top sramc_checker #(
    .ADDR_W   (ADDR_W),
    .LANES    (DATA_W / 8),
    .CLK_NS   (CLK_NS),
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .WP_CYC   (WP_CYC),
    .REC_CYC  (REC_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (sram_cs_n),
    .we_n      (sram_we_n),
    .oe_n      (sram_oe_n),
    .addr      (sram_addr),
    .drive     (dq_drive),
    .ready     (req_ready),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_sramc_top.sv
`timescale 1ns/1ps
module tb_sramc_top;
    localparam int CLK_NS = 8;
    localparam int RD   = (70 + CLK_NS - 1) / CLK_NS;
    localparam int TURN = (25 + CLK_NS - 1) / CLK_NS;
    localparam int WP   = (55 + CLK_NS - 1) / CLK_NS;
    localparam int WBUSY = TURN + WP + 1;
    localparam int RBUSY = RD + TURN;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] sram_addr;
    logic        sram_cs_n, sram_we_n, sram_oe_n;
    logic [1:0]  sram_bc_n;
    wire  [15:0] sram_dq;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    sramc_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_bc_n(sram_bc_n), .sram_dq(sram_dq)
    );

    // memory model: 32 words keyed by top and low address bits
    logic [15:0] mem [32];
    logic [4:0]  key;
    logic        rd_en;
    assign key   = {sram_addr[18], sram_addr[3:0]};
    assign rd_en = !sram_cs_n && !sram_oe_n && sram_we_n;
    assign sram_dq[7:0]  = (rd_en && !sram_bc_n[0]) ? mem[key][7:0]  : 8'hzz;
    assign sram_dq[15:8] = (rd_en && !sram_bc_n[1]) ? mem[key][15:8] : 8'hzz;

    always @(posedge clk) begin
        if (!sram_cs_n && !sram_we_n) begin
            if (!sram_bc_n[0]) mem[key][7:0]  <= sram_dq[7:0];
            if (!sram_bc_n[1]) mem[key][15:8] <= sram_dq[15:8];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // pin monitor
    int          we_lo = 0;
    logic        prev_we = 1'b1;
    logic        prev_cs = 1'b1;
    logic [18:0] prev_addr = '0;
    logic [15:0] cur_wdata = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!sram_we_n) begin
                we_lo++;
                check("R4 oe high during write strobe", {31'd0, sram_oe_n}, 32'd1);
                check("R6 bus holds write data", {16'd0, sram_dq}, {16'd0, cur_wdata});
            end else if (!prev_we) begin
                check("R4 write strobe length", we_lo, WP);
                check("R6 data held after strobe", {16'd0, sram_dq}, {16'd0, cur_wdata});
                we_lo = 0;
            end
            if (!sram_cs_n && !prev_cs)
                check("R5 address stable under select", {13'd0, sram_addr}, {13'd0, prev_addr});
            prev_we   = sram_we_n;
            prev_cs   = sram_cs_n;
            prev_addr = sram_addr;
        end
    end

    task automatic xfer(input bit wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] rd);
        int cyc;
        int nrsp;
        int rsp_at;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        if (wr) cur_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0; nrsp = 0; rsp_at = -1; rd = '0;
        while (!req_ready && cyc < 100) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (rsp_valid) begin
                nrsp++;
                rsp_at = cyc;
                rd = rsp_rdata;
            end
        end
        check("R7 busy window", cyc, wr ? WBUSY : RBUSY);
        check("R8 response count", nrsp, wr ? 0 : 1);
        if (!wr) check("R1 response latency", rsp_at, RD);
    endtask

    function automatic logic [15:0] lane_keep(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    logic [15:0] shadow [16];

    initial begin
        logic [15:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 ready in reset", {31'd0, req_ready}, 32'd1);
        check("R9 pins idle in reset", {27'd0, sram_cs_n, sram_we_n, sram_oe_n, sram_bc_n}, 32'h1F);
        rst = 1'b0;
        @(negedge clk);
        check("R9 ready after reset", {31'd0, req_ready}, 32'd1);
        check("R9 no response after reset", {31'd0, rsp_valid}, 32'd0);
        check("R9 pins idle after reset", {27'd0, sram_cs_n, sram_we_n, sram_oe_n, sram_bc_n}, 32'h1F);

        for (int i = 0; i < 16; i++) begin
            logic [18:0] a;
            a = {i[0], 14'(i * 37 + 5), i[3:0]};
            shadow[i] = 16'(i * 16'h0F1D) ^ 16'h5AC3;
            xfer(1'b1, a, shadow[i], 2'b11, r);
            xfer(1'b0, a, 16'h0, 2'b11, r);
            check("R1 full read after full write", {16'd0, r}, {16'd0, shadow[i]});
            for (int m = 0; m < 4; m++) begin
                logic [15:0] d;
                d = 16'(i * 16'h1357) ^ 16'(m * 16'h2468) ^ 16'hA5C3;
                xfer(1'b1, a, d, 2'(m), r);
                shadow[i] = (shadow[i] & ~lane_keep(2'(m))) | (d & lane_keep(2'(m)));
                xfer(1'b0, a, 16'h0, 2'b11, r);
                check("R3 masked write merges bytes", {16'd0, r}, {16'd0, shadow[i]});
                xfer(1'b0, a, 16'h0, 2'(m), r);
                check("R2 masked read zeroes unselected bytes", {16'd0, r},
                      {16'd0, shadow[i] & lane_keep(2'(m))});
            end
        end
        // words written earlier must be undisturbed by later addresses
        for (int i = 0; i < 16; i++) begin
            logic [18:0] a;
            a = {i[0], 14'(i * 37 + 5), i[3:0]};
            xfer(1'b0, a, 16'h0, 2'b11, r);
            check("R3 other words untouched", {16'd0, r}, {16'd0, shadow[i]});
        end
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule